// File: doc/BRIEF.md
# Network Microcode Boot Receiver

This block takes in a microcode image that a boot server streams as a series of reply packets, and places the payload words into a word-addressed memory. A pulse on `start`, together with a base address, arms it. Each packet arrives as one header beat on a valid/ready header channel. The header carries the packet identifier split into a high and a low half, the second word of the sender's socket, and the payload length in 16-bit words. The payload words then follow on a valid/ready payload channel, and the final word of the packet is flagged with `pl_last`. The receiver never answers the sender: the server pushes packets as fast as it can, and the receiver either uses a packet or drops it.

The high half of the packet identifier holds the protocol version. The low half holds the packet's sequence number. The very first packet after `start` is always thrown away, whatever it contains. A later packet with a length of zero words is the end marker and completes the transfer. When a packet passes every check, its words are written to consecutive addresses, continuing from where the previous packet stopped. A packet with a length that does not fit the rules, a break in the sequence, or a `pl_last` in the wrong place raises `err`.

Back-pressure rules: `hdr_ready` is high only while the block waits for a header, or while it is idle. `pl_ready` is high only while a payload is being consumed or dropped, or while the block is idle. While it is idle (after reset, `done` or `err`), the block accepts and discards everything on both channels, so the sender never stalls. A beat moves only in a cycle where both valid and ready are high. The sender must hold its data steady until that cycle.

Top module: `mcboot_rx`

## Requirements
- R1: After reset the block is idle: `done`, `err` and `mem_we` are low, and `hdr_ready` and `pl_ready` are both high.
- R2: The first header accepted after `start`, together with its payload, is discarded whatever its fields hold. This includes a zero length, which then does not set `done`. No memory write comes from that first packet.
- R3: A header whose socket word is not 4 is ignored, and so is its payload. No writes take place, and neither flag nor the sequence state changes.
- R4: A header whose identifier high half (the version) is not 1 is ignored in the same way as in R3.
- R5: The words of accepted packets are written in arrival order to consecutive addresses, starting at `base_addr` as sampled at `start`. The address carries on across packets.
- R6: An accepted header with a length of zero sets `done`. After that, no further writes occur.
- R7: An accepted header whose length is not a multiple of 3 words sets `err`. None of its words are written.
- R8: The identifier low half is the sequence number. The first accepted data packet sets the expected value. Every later data packet must carry the previous number plus 1 (modulo 2^16). Otherwise `err` is set and none of its words are written.
- R9: In an accepted packet, `pl_last` must be high exactly on the word the header length declares to be final. On a mismatch, `err` is set and that beat and every later beat of the packet are not written.
- R10: After `done` or `err`, the block stays idle and writes nothing, sinking all beats, until the next `start`. `start` clears both flags. `done` and `err` are never high together.
- R11: While waiting for a header, `pl_ready` is low. While consuming payload, `hdr_ready` is low. `mem_we` is high only in a cycle with a payload handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that arms a new transfer |
| base_addr | input | 12 | First write address, sampled with `start` |
| hdr_valid | input | 1 | Header beat is valid |
| hdr_ready | output | 1 | Block can take a header beat |
| hdr_id_hi | input | 16 | Packet identifier high half (version) |
| hdr_id_lo | input | 16 | Packet identifier low half (sequence number) |
| hdr_socket | input | 16 | Second word of the sender's socket |
| hdr_words | input | 8 | Payload length in 16-bit words |
| pl_valid | input | 1 | Payload word is valid |
| pl_ready | output | 1 | Block can take a payload word |
| pl_data | input | 16 | Payload word |
| pl_last | input | 1 | Final word of the packet |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 12 | Memory write address |
| mem_data | output | 16 | Memory write data |
| done | output | 1 | End marker received |
| err | output | 1 | Transfer aborted by a check |

## Verification
The main path is tried with a dummy packet of real-looking data and then with a dummy end marker. Together these show that the discard is tied to the packet's position, not to its contents. Multi-packet streams with different lengths and two base addresses show whether the address runs on across packet edges or restarts at each one. Packets that are good except for one field (socket word, version, sequence, length, or a misplaced `pl_last`) are placed between good packets, which separates the two outcomes "ignored and the stream goes on" and "aborted". A sweep of declared lengths from 1 to 9 words then tells accepted lengths apart from rejected ones, and each sweep case is followed by an end marker to show whether the block is still running.

// File: rtl/mcboot_pkg.sv
package mcboot_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_TAKE,
    ST_SKIP
  } rx_state_e;

  typedef enum logic [2:0] {
    HV_DROP,
    HV_END,
    HV_BADLEN,
    HV_BADSEQ,
    HV_DATA
  } hdr_verdict_e;

endpackage

// File: rtl/mcboot_hdr_judge.sv
module mcboot_hdr_judge
  import mcboot_pkg::*;
#(
  parameter int ID_W      = 16,
  parameter int LEN_W     = 8,
  parameter int VERSION   = 1,
  parameter int SOCK_WORD = 4,
  parameter int GROUP     = 3
) (
  input  logic [ID_W-1:0]  id_hi,
  input  logic [ID_W-1:0]  id_lo,
  input  logic [ID_W-1:0]  socket,
  input  logic [LEN_W-1:0] words,
  input  logic             have_seq,
  input  logic [ID_W-1:0]  exp_seq,
  output hdr_verdict_e     verdict
);

  localparam logic [ID_W-1:0]  VER_VAL  = ID_W'(VERSION);
  localparam logic [ID_W-1:0]  SOCK_VAL = ID_W'(SOCK_WORD);
  localparam logic [LEN_W-1:0] GRP_VAL  = LEN_W'(GROUP);

  logic [LEN_W-1:0] leftover;
  assign leftover = words % GRP_VAL;

  always_comb begin
    if (socket != SOCK_VAL || id_hi != VER_VAL)
      verdict = HV_DROP;
    else if (words == '0)
      verdict = HV_END;
    else if (leftover != '0)
      verdict = HV_BADLEN;
    else if (have_seq && id_lo != exp_seq)
      verdict = HV_BADSEQ;
    else
      verdict = HV_DATA;
  end

endmodule

// File: rtl/mcboot_wr_track.sv
module mcboot_wr_track #(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_base,
  input  logic [ADDR_W-1:0] base,
  input  logic              load_len,
  input  logic [LEN_W-1:0]  len,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              final_beat
);

  logic [LEN_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr   <= '0;
      remain <= '0;
    end else begin
      if (load_base)
        addr <= base;
      else if (step)
        addr <= addr + 1'b1;
      if (load_len)
        remain <= len;
      else if (step)
        remain <= remain - 1'b1;
    end
  end

  assign final_beat = (remain == LEN_W'(1));

  a_r5_addr_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_base) |=> (addr == $past(addr) + 1'b1));

  a_r9_no_step_past_end: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_len) |-> (remain != '0));

endmodule

// File: rtl/mcboot_rx.sv
module mcboot_rx
  import mcboot_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 16,
  parameter int ID_W      = 16,
  parameter int LEN_W     = 8,
  parameter int VERSION   = 1,
  parameter int SOCK_WORD = 4,
  parameter int GROUP     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic [ID_W-1:0]   hdr_id_hi,
  input  logic [ID_W-1:0]   hdr_id_lo,
  input  logic [ID_W-1:0]   hdr_socket,
  input  logic [LEN_W-1:0]  hdr_words,
  input  logic              pl_valid,
  output logic              pl_ready,
  input  logic [DATA_W-1:0] pl_data,
  input  logic              pl_last,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              done,
  output logic              err
);

  rx_state_e    state;
  hdr_verdict_e verdict;
  logic         first_pend;
  logic         have_seq;
  logic [ID_W-1:0] exp_seq;
  logic         hdr_fire, pl_fire, final_beat, beat_ok, take_hdr;

  assign hdr_ready = (state == ST_IDLE) || (state == ST_HDR);
  assign pl_ready  = (state == ST_IDLE) || (state == ST_TAKE) || (state == ST_SKIP);
  assign hdr_fire  = hdr_valid && hdr_ready;
  assign pl_fire   = pl_valid && pl_ready;

  mcboot_hdr_judge #(
    .ID_W(ID_W), .LEN_W(LEN_W), .VERSION(VERSION),
    .SOCK_WORD(SOCK_WORD), .GROUP(GROUP)
  ) u_judge (
    .id_hi    (hdr_id_hi),
    .id_lo    (hdr_id_lo),
    .socket   (hdr_socket),
    .words    (hdr_words),
    .have_seq (have_seq),
    .exp_seq  (exp_seq),
    .verdict  (verdict)
  );

  assign beat_ok  = (state == ST_TAKE) && pl_fire && (pl_last == final_beat) && !start;
  assign take_hdr = (state == ST_HDR) && hdr_fire && !first_pend &&
                    (verdict == HV_DATA) && !start;

  mcboot_wr_track #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_base  (start),
    .base       (base_addr),
    .load_len   (take_hdr),
    .len        (hdr_words),
    .step       (beat_ok),
    .addr       (mem_addr),
    .final_beat (final_beat)
  );

  assign mem_we   = beat_ok;
  assign mem_data = pl_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      first_pend <= 1'b0;
      have_seq   <= 1'b0;
      exp_seq    <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
    end else if (start) begin
      state      <= ST_HDR;
      first_pend <= 1'b1;
      have_seq   <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      unique case (state)
        ST_HDR: if (hdr_fire) begin
          if (first_pend) begin
            first_pend <= 1'b0;
            state      <= (hdr_words != '0) ? ST_SKIP : ST_HDR;
          end else begin
            unique case (verdict)
              HV_DROP: state <= (hdr_words != '0) ? ST_SKIP : ST_HDR;
              HV_END: begin
                done  <= 1'b1;
                state <= ST_IDLE;
              end
              HV_BADLEN, HV_BADSEQ: begin
                err   <= 1'b1;
                state <= ST_IDLE;
              end
              default: begin
                exp_seq  <= hdr_id_lo + 1'b1;
                have_seq <= 1'b1;
                state    <= ST_TAKE;
              end
            endcase
          end
        end
        ST_TAKE: if (pl_fire) begin
          if (pl_last != final_beat) begin
            err   <= 1'b1;
            state <= ST_IDLE;
          end else if (pl_last) begin
            state <= ST_HDR;
          end
        end
        ST_SKIP: if (pl_fire && pl_last) state <= ST_HDR;
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r6_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_we);

  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  a_r7_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err);

  a_r11_write_not_in_header: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (pl_valid && !hdr_ready));

  a_r2_dummy_never_written: assert property (@(posedge clk) disable iff (!rst_n)
    first_pend |-> !mem_we);

endmodule

// File: tb/mcboot_rx_test.sv
`timescale 1ns/1ps
module mcboot_rx_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] base_addr = '0;
  logic        hdr_valid = 1'b0;
  logic        hdr_ready;
  logic [15:0] hdr_id_hi = '0, hdr_id_lo = '0, hdr_socket = '0;
  logic [7:0]  hdr_words = '0;
  logic        pl_valid = 1'b0;
  logic        pl_ready;
  logic [15:0] pl_data = '0;
  logic        pl_last = 1'b0;
  logic        mem_we;
  logic [11:0] mem_addr;
  logic [15:0] mem_data;
  logic        done, err;

  int checks = 0;
  int fails = 0;
  int wr_cnt = 0;
  logic [15:0] tb_mem [0:4095];

  always #10 clk = ~clk;

  mcboot_rx uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_id_hi(hdr_id_hi),
    .hdr_id_lo(hdr_id_lo), .hdr_socket(hdr_socket), .hdr_words(hdr_words),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data), .pl_last(pl_last),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
    .done(done), .err(err)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      tb_mem[mem_addr] <= mem_data;
      wr_cnt <= wr_cnt + 1;
    end
  end

  function automatic logic [15:0] pat(input int seq, input int idx);
    return 16'((seq << 8) ^ idx ^ 16'hA500);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic send_hdr(input int hi, input int lo, input int sk, input int n);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_id_hi = 16'(hi); hdr_id_lo = 16'(lo);
    hdr_socket = 16'(sk); hdr_words = 8'(n);
    #1;
    while (!hdr_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    hdr_valid = 1'b0;
  endtask

  task automatic send_pl(input int n, input int seq, input int last_at);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pl_valid = 1'b1; pl_data = pat(seq, i); pl_last = (i == last_at);
      #1;
      while (!pl_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      pl_valid = 1'b0; pl_last = 1'b0;
    end
  endtask

  task automatic pkt(input int hi, input int lo, input int sk, input int n);
    send_hdr(hi, lo, sk, n);
    if (n > 0) send_pl(n, lo, n - 1);
  endtask

  task automatic do_start(input int base);
    @(negedge clk); start = 1'b1; base_addr = 12'(base);
    @(negedge clk); start = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic chk_mem(input int base, input int seq, input int n, input string tag);
    for (int i = 0; i < n; i++)
      check(tb_mem[base + i] == pat(seq, i), tag, int'(tb_mem[base + i]), int'(pat(seq, i)));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(done == 0 && err == 0, "R1 flags after reset", {done, err}, 0);
    check(mem_we == 0, "R1 no write after reset", mem_we, 0);
    check(hdr_ready && pl_ready, "R1 idle sinks both channels", {hdr_ready, pl_ready}, 3);

    // Run A: base 0x100
    do_start(12'h100);
    check(hdr_ready == 1 && pl_ready == 0, "R11 waiting for header", {hdr_ready, pl_ready}, 2);
    pkt(1, 0, 4, 6);                       // dummy, fully valid-looking
    settle();
    check(wr_cnt == 0, "R2 dummy packet not written", wr_cnt, 0);
    send_hdr(1, 1, 4, 6);
    @(negedge clk);
    check(hdr_ready == 0, "R11 no header during payload", hdr_ready, 0);
    send_pl(6, 1, 5);
    pkt(1, 2, 4, 3);
    settle();
    check(wr_cnt == 9, "R5 nine words written", wr_cnt, 9);
    chk_mem(12'h100, 1, 6, "R5 packet 1 content");
    chk_mem(12'h106, 2, 3, "R5 packet 2 continues address");
    w0 = wr_cnt;
    pkt(1, 3, 5, 3);                       // wrong socket word
    settle();
    check(wr_cnt == w0 && err == 0, "R3 bad socket ignored", wr_cnt - w0, 0);
    pkt(2, 3, 4, 3);                       // wrong version
    settle();
    check(wr_cnt == w0 && err == 0, "R4 bad version ignored", wr_cnt - w0, 0);
    pkt(1, 3, 4, 3);                       // sequence still expects 3
    settle();
    check(wr_cnt == w0 + 3 && err == 0, "R3 R4 sequence unchanged after ignored", wr_cnt - w0, 3);
    chk_mem(12'h109, 3, 3, "R5 packet 3 content");
    pkt(1, 4, 4, 0);                       // end marker
    settle();
    check(done == 1 && err == 0, "R6 end marker sets done", {done, err}, 2);
    w0 = wr_cnt;
    pkt(1, 5, 4, 3);
    settle();
    check(wr_cnt == w0 && done == 1, "R10 idle after done", wr_cnt - w0, 0);

    // Run B: dummy end marker, then a sequence gap
    do_start(12'h200);
    check(done == 0 && err == 0, "R10 start clears flags", {done, err}, 0);
    pkt(1, 9, 4, 0);
    settle();
    check(done == 0, "R2 dummy end marker discarded", done, 0);
    w0 = wr_cnt;
    pkt(1, 16'hFFFF, 4, 3);
    pkt(1, 0, 4, 3);                       // wraps to 0
    settle();
    check(wr_cnt == w0 + 6 && err == 0, "R8 sequence wraps", wr_cnt - w0, 6);
    chk_mem(12'h203, 0, 3, "R8 wrapped packet content");
    w0 = wr_cnt;
    pkt(1, 2, 4, 3);                       // skipped 1
    settle();
    check(err == 1 && wr_cnt == w0, "R8 skipped sequence aborts", wr_cnt - w0, 0);
    check(done == 0, "R10 done stays low with err", done, 0);

    // Run C: pl_last early
    do_start(12'h300);
    pkt(1, 0, 4, 3);
    w0 = wr_cnt;
    send_hdr(1, 7, 4, 3);
    send_pl(2, 7, 1);
    settle();
    check(err == 1 && wr_cnt == w0 + 1, "R9 early last stops writes", wr_cnt - w0, 1);
    check(tb_mem[12'h300] == pat(7, 0), "R9 word before mismatch kept", int'(tb_mem[12'h300]), int'(pat(7, 0)));

    // Sweep of declared lengths
    for (int len = 1; len <= 9; len++) begin
      int b;
      b = 12'h400 + len * 16;
      do_start(b);
      pkt(1, 0, 4, 3);
      w0 = wr_cnt;
      pkt(1, 16'h40, 4, len);
      pkt(1, 16'h41, 4, 0);
      settle();
      if (len % 3 == 0) begin
        check(wr_cnt == w0 + len && done == 1 && err == 0, "R7 multiple of three accepted", wr_cnt - w0, len);
        chk_mem(b, 16'h40, len, "R5 sweep content");
      end else begin
        check(wr_cnt == w0 && err == 1 && done == 0, "R7 bad length flagged", wr_cnt - w0, 0);
      end
    end

    finish_run();
  end

endmodule